// File: doc/BRIEF.md
# Security-Aliased System Register Window Filter

This block sits between a bus requester and a block of banked system registers. It decodes a container address space that holds two windows. The first is the main register window, 4 KiB at the bottom of the container. The second is an optional non-secure alias window, also 4 KiB, at offset 0x20000. Every request carries an address, a read/write flag, write data, a secure attribute and an unprivileged attribute. Requests to the main window go downstream unchanged.

The alias window lets secure software reach the non-secure bank of every banked register. A secure request to the alias is re-issued downstream at the same offset with its secure attribute cleared, so the register block picks its non-secure copy from the forwarded attribute. A non-secure request to the alias is answered locally. A privileged read returns zero and a privileged write is dropped. An unprivileged access of either kind gets an error response. The downstream side sees neither.

A parameter decides whether the alias window exists. With the alias window, the container spans 0x21000 bytes. Without it, the container spans 0x1000 bytes. A second parameter says whether the security extension exists. Without the extension, every requester counts as non-secure.

Top module: `sreg_alias_filter`

## Requirements
- R1: A request whose address is below 0x1000 is forwarded downstream. The forwarded request keeps the low 12 address bits as the offset, with the write flag, the write data and the effective secure attribute unchanged.
- R2: When the alias exists (HAS_ALIAS=1), a request with an address in 0x20000..0x20FFF and an effective secure attribute of 1 is forwarded at offset addr[11:0] with dn_secure=0. A write made this way changes only the non-secure copy of a banked register.
- R3: A non-secure privileged read of the alias window completes with rsp_rdata=0 and rsp_err=0, and dn_valid stays low.
- R4: A non-secure privileged write of the alias window completes with rsp_err=0. It is not forwarded, and neither register copy changes.
- R5: A non-secure unprivileged read or write of the alias window completes with rsp_err=1 and is not forwarded.
- R6: An address in neither window completes with rsp_err=1 and is not forwarded. This covers 0x1000..0x1FFFF, addresses at or above 0x21000, and all of 0x20000..0x20FFF when HAS_ALIAS=0.
- R7: With SEC_EXT=0, the effective secure attribute is 0 whatever req_secure says. Main-window requests are then forwarded with dn_secure=0, and alias requests follow R3 to R5.
- R8: rsp_valid is high exactly in the cycle after a request is accepted (req_valid and req_ready both high). For a forwarded request, rsp_rdata and rsp_err are the downstream dn_rdata and dn_err of that cycle.
- R9: For a forwarded request, req_ready equals dn_ready. For a request answered locally, req_ready is 1.
- R10: While rst_n is low, rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted in this cycle when high together with req_valid |
| req_addr | input | ADDR_W | Byte address within the container |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | DATA_W | Write data |
| req_secure | input | 1 | Requester secure attribute |
| req_user | input | 1 | Requester is unprivileged |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Error (bus fault) response |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream ready |
| dn_addr | output | OFF_W | Register offset within the window |
| dn_write | output | 1 | Downstream write flag |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_secure | output | 1 | Rewritten secure attribute for bank selection |
| dn_rdata | input | DATA_W | Downstream read data, valid the cycle after its handshake |
| dn_err | input | 1 | Downstream error, valid the cycle after its handshake |

## Verification
On every cycle, the assertions check the per-request rules. Main-window requests keep their offset and effective attribute. Alias requests that go downstream are always non-secure, and locally answered alias requests never raise dn_valid. Responses appear exactly one cycle after acceptance and carry the right error or zero data. Only the bench's scenarios show the end-to-end effects. Through a banked stub, they show that a secure alias write lands in the non-secure copy alone, and that a dropped write leaves both copies untouched. They also show that the two parameter settings change the decode and the attribute handling as required, and that backpressure holds the request until the downstream side accepts it.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic [1:0] {
    REG_NONE  = 2'd0,
    REG_MAIN  = 2'd1,
    REG_ALIAS = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    ACT_FWD   = 2'd0,
    ACT_ZERO  = 2'd1,
    ACT_FAULT = 2'd2
  } act_e;

  // Which window an address falls in.
  function automatic region_e classify(input logic [31:0] a,
                                       input int unsigned win,
                                       input int unsigned alias_base,
                                       input bit has_alias);
    if (a < win) return REG_MAIN;
    if (has_alias && a >= alias_base && a < alias_base + win) return REG_ALIAS;
    return REG_NONE;
  endfunction

  // What to do with a request, given its window and effective attributes.
  function automatic act_e choose(input region_e r, input logic eff_sec,
                                  input logic user);
    case (r)
      REG_MAIN:  return ACT_FWD;
      REG_ALIAS: begin
        if (eff_sec) return ACT_FWD;
        if (user)    return ACT_FAULT;
        return ACT_ZERO;
      end
      default:   return ACT_FAULT;
    endcase
  endfunction

  // Secure attribute carried downstream.
  function automatic logic fwd_attr(input region_e r, input logic eff_sec);
    return (r == REG_MAIN) ? eff_sec : 1'b0;
  endfunction

endpackage

// File: rtl/sreg_win_decode.sv
module sreg_win_decode
  import sreg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned WIN_BYTES  = 32'h1000,
  parameter int unsigned ALIAS_BASE = 32'h20000,
  parameter bit          HAS_ALIAS  = 1'b1,
  localparam int unsigned OFF_W     = $clog2(WIN_BYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [OFF_W-1:0]  offset
);

  logic [31:0] addr_ext;

  assign addr_ext = 32'(addr);
  assign region   = classify(addr_ext, WIN_BYTES, ALIAS_BASE, HAS_ALIAS);
  assign offset   = addr[OFF_W-1:0];

endmodule

// File: rtl/sreg_attr_rewrite.sv
module sreg_attr_rewrite
  import sreg_pkg::*;
#(
  parameter bit SEC_EXT = 1'b1
) (
  input  region_e region,
  input  logic    secure,
  input  logic    user,
  output act_e    act,
  output logic    fwd_secure
);

  logic eff_sec;

  generate
    if (SEC_EXT) begin : g_sec
      assign eff_sec = secure;
    end else begin : g_nosec
      logic unused_sec;
      assign unused_sec = secure;
      assign eff_sec    = 1'b0;
    end
  endgenerate

  assign act        = choose(region, eff_sec, user);
  assign fwd_secure = fwd_attr(region, eff_sec);

endmodule

// File: rtl/sreg_resp_stage.sv
module sreg_resp_stage
  import sreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  act_e              act,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              dn_err,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  logic vld_q;
  act_e kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      kind_q <= ACT_ZERO;
    end else begin
      vld_q <= accept;
      if (accept) kind_q <= act;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_rdata = (vld_q && kind_q == ACT_FWD) ? dn_rdata : '0;
  assign rsp_err   = vld_q && ((kind_q == ACT_FAULT) ||
                               (kind_q == ACT_FWD && dn_err));

endmodule

// File: rtl/sreg_alias_filter.sv
module sreg_alias_filter
  import sreg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned WIN_BYTES  = 32'h1000,
  parameter int unsigned ALIAS_BASE = 32'h20000,
  parameter bit          HAS_ALIAS  = 1'b1,
  parameter bit          SEC_EXT    = 1'b1,
  localparam int unsigned OFF_W     = $clog2(WIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_secure,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [OFF_W-1:0]  dn_addr,
  output logic              dn_write,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              dn_secure,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              dn_err
);

  region_e region;
  act_e    act;
  logic    fwd_secure;

  // Named events for the checker.
  logic in_main, in_alias, fwd_evt, acc_evt;

  sreg_win_decode #(
    .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES),
    .ALIAS_BASE(ALIAS_BASE), .HAS_ALIAS(HAS_ALIAS)
  ) u_dec (
    .addr(req_addr), .region(region), .offset(dn_addr)
  );

  sreg_attr_rewrite #(.SEC_EXT(SEC_EXT)) u_attr (
    .region(region), .secure(req_secure), .user(req_user),
    .act(act), .fwd_secure(fwd_secure)
  );

  assign in_main   = (region == REG_MAIN);
  assign in_alias  = (region == REG_ALIAS);
  assign fwd_evt   = (act == ACT_FWD);

  assign dn_valid  = req_valid && fwd_evt;
  assign dn_write  = req_write;
  assign dn_wdata  = req_wdata;
  assign dn_secure = fwd_secure;
  assign req_ready = fwd_evt ? dn_ready : 1'b1;
  assign acc_evt   = req_valid && req_ready;

  sreg_resp_stage #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .accept(acc_evt), .act(act),
    .dn_rdata(dn_rdata), .dn_err(dn_err),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

endmodule

// File: rtl/sreg_alias_filter_chk.sv
module sreg_alias_filter_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 12,
  parameter bit          SEC_EXT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              req_secure,
  input logic              req_user,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [OFF_W-1:0]  dn_addr,
  input logic              dn_secure,
  input logic [DATA_W-1:0] dn_rdata,
  input logic              dn_err,
  input logic              in_main,
  input logic              in_alias,
  input logic              acc_evt
);

  logic eff_sec;
  assign eff_sec = (SEC_EXT != 0) && req_secure;

  assert_main_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && in_main |-> dn_secure == eff_sec && dn_addr == req_addr[OFF_W-1:0]);

  assert_alias_ns_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && in_alias |-> !dn_secure && dn_addr == req_addr[OFF_W-1:0]);

  assert_alias_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && in_alias && !eff_sec |-> !dn_valid && req_ready);

  assert_raz_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt && in_alias && !eff_sec && !req_user && !req_write
      |=> rsp_valid && !rsp_err && rsp_rdata == '0);

  assert_wi_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt && in_alias && !eff_sec && !req_user && req_write
      |=> rsp_valid && !rsp_err);

  assert_user_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt && in_alias && !eff_sec && req_user |=> rsp_valid && rsp_err);

  assert_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !in_main && !in_alias |-> !dn_valid);

  assert_outside_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt && !in_main && !in_alias |=> rsp_valid && rsp_err);

  assert_nosec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (SEC_EXT == 0) && dn_valid |-> !dn_secure);

  assert_rsp_after_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> rsp_valid);

  assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_evt |=> !rsp_valid);

  assert_fwd_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt && dn_valid |=> rsp_rdata == dn_rdata && rsp_err == dn_err);

  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> req_ready == dn_ready);

  always_comb begin
    if (!rst_n) assert_reset_R10: assert (!rsp_valid);
  end

endmodule

bind sreg_alias_filter sreg_alias_filter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .SEC_EXT(SEC_EXT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_write(req_write), .req_secure(req_secure),
  .req_user(req_user), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .dn_valid(dn_valid), .dn_ready(dn_ready),
  .dn_addr(dn_addr), .dn_secure(dn_secure), .dn_rdata(dn_rdata),
  .dn_err(dn_err), .in_main(in_main), .in_alias(in_alias), .acc_evt(acc_evt)
);

// File: tb/sim_sreg_alias_filter.sv
`timescale 1ns/1ps

module sim_bank_stub (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  logic        ready,
  input  logic [11:0] addr,
  input  logic        write,
  input  logic [31:0] wdata,
  input  logic        secure,
  output logic [31:0] rdata,
  output logic        err,
  output logic [31:0] copy_s,
  output logic [31:0] copy_ns,
  output int          hits,
  output logic        last_sec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0; err <= 1'b0; copy_s <= 32'h5EC0_0000;
      copy_ns <= 32'h0A5E_0000; hits <= 0; last_sec <= 1'b0;
    end else if (valid && ready) begin
      hits     <= hits + 1;
      last_sec <= secure;
      err      <= (addr == 12'hFF0);
      if (write) begin
        if (addr == 12'h010) begin
          if (secure) copy_s <= wdata; else copy_ns <= wdata;
        end
        rdata <= '0;
      end else if (addr == 12'h010) rdata <= secure ? copy_s : copy_ns;
      else rdata <= {secure ? 8'h5E : 8'h4E, 12'h000, addr};
    end
  end
endmodule

module sim_sreg_alias_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0, req_user = 1'b0;
  logic [17:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        stub_ready = 1'b1;

  // Index 0: alias and security extension present. Index 1: neither.
  logic        rdy   [2];
  logic        rv    [2];
  logic [31:0] rd    [2];
  logic        re    [2];
  logic        dv    [2];
  logic [11:0] da    [2];
  logic        dw    [2];
  logic [31:0] dwd   [2];
  logic        ds    [2];
  logic [31:0] srd   [2];
  logic        serr  [2];
  logic [31:0] cs    [2];
  logic [31:0] cns   [2];
  int          hits  [2];
  logic        lsec  [2];

  sreg_alias_filter #(.HAS_ALIAS(1'b1), .SEC_EXT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_secure(req_secure), .req_user(req_user), .rsp_valid(rv[0]),
    .rsp_rdata(rd[0]), .rsp_err(re[0]), .dn_valid(dv[0]), .dn_ready(stub_ready),
    .dn_addr(da[0]), .dn_write(dw[0]), .dn_wdata(dwd[0]), .dn_secure(ds[0]),
    .dn_rdata(srd[0]), .dn_err(serr[0])
  );
  sim_bank_stub s0 (
    .clk(clk), .rst_n(rst_n), .valid(dv[0]), .ready(stub_ready), .addr(da[0]),
    .write(dw[0]), .wdata(dwd[0]), .secure(ds[0]), .rdata(srd[0]), .err(serr[0]),
    .copy_s(cs[0]), .copy_ns(cns[0]), .hits(hits[0]), .last_sec(lsec[0])
  );

  sreg_alias_filter #(.HAS_ALIAS(1'b0), .SEC_EXT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_secure(req_secure), .req_user(req_user), .rsp_valid(rv[1]),
    .rsp_rdata(rd[1]), .rsp_err(re[1]), .dn_valid(dv[1]), .dn_ready(stub_ready),
    .dn_addr(da[1]), .dn_write(dw[1]), .dn_wdata(dwd[1]), .dn_secure(ds[1]),
    .dn_rdata(srd[1]), .dn_err(serr[1])
  );
  sim_bank_stub s1 (
    .clk(clk), .rst_n(rst_n), .valid(dv[1]), .ready(stub_ready), .addr(da[1]),
    .write(dw[1]), .wdata(dwd[1]), .secure(ds[1]), .rdata(srd[1]), .err(serr[1]),
    .copy_s(cs[1]), .copy_ns(cns[1]), .hits(hits[1]), .last_sec(lsec[1])
  );

  int total = 0, passed = 0;
  logic [31:0] m_s [2];
  logic [31:0] m_ns[2];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  // Outcome: 0 forwarded, 1 answered locally OK, 2 error.
  function automatic int outcome(input int d, input int a, input bit s, input bit u);
    bit has_alias = (d == 0);
    bit es = (d == 0) && s;
    if (a < 4096) return 0;
    if (has_alias && a >= 'h20000 && a <= 'h20FFF) return es ? 0 : (u ? 2 : 1);
    return 2;
  endfunction

  task automatic txn(input int a, input bit w, input bit s, input bit u, input logic [31:0] wd);
    int h0 [2];
    int o, off;
    logic [31:0] exp_rd;
    bit exp_sec, exp_err;
    @(negedge clk);
    for (int d = 0; d < 2; d++) h0[d] = hits[d];
    req_addr = 18'(a); req_write = w; req_wdata = wd; req_secure = s; req_user = u;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    off = a & 'hFFF;
    for (int d = 0; d < 2; d++) begin
      o = outcome(d, a, s, u);
      exp_sec = (a < 4096) ? ((d == 0) && s) : 1'b0;
      chk(rv[d] == 1'b1, "R8 rsp_valid after accept", 32'(rv[d]), 1);
      chk(hits[d] == h0[d] + (o == 0 ? 1 : 0),
          o == 0 ? "R1/R2 forwarded" : (o == 1 ? "R3/R4 not forwarded" :
          (a < 'h20000 || a > 'h20FFF || d == 1 ? "R6 not forwarded" : "R5 not forwarded")),
          32'(hits[d] - h0[d]), 32'(o == 0));
      exp_err = (o == 2) || (o == 0 && off == 'hFF0);
      chk(re[d] == exp_err, o == 2 ? (d == 1 ? "R6/R7 error" : "R5/R6 error") : "R8 error flag",
          32'(re[d]), 32'(exp_err));
      if (o == 0)
        chk(lsec[d] == exp_sec, d == 1 ? "R7 forwarded attr" : (a < 4096 ? "R1 attr kept" : "R2 attr cleared"),
            32'(lsec[d]), 32'(exp_sec));
      if (o == 0 && w && off == 'h10) begin
        if (exp_sec) m_s[d] = wd; else m_ns[d] = wd;
      end
      if (!w && o != 2) begin
        if (o == 1) exp_rd = '0;
        else if (off == 'h10) exp_rd = exp_sec ? m_s[d] : m_ns[d];
        else exp_rd = {exp_sec ? 8'h5E : 8'h4E, 12'h000, 12'(off)};
        chk(rd[d] == exp_rd, o == 1 ? "R3 read as zero" : "R1/R2 read data", rd[d], exp_rd);
      end
      chk(cs[d] == m_s[d], "R2/R4 secure copy", cs[d], m_s[d]);
      chk(cns[d] == m_ns[d], "R2/R4 non-secure copy", cns[d], m_ns[d]);
    end
    @(negedge clk);
    for (int d = 0; d < 2; d++)
      chk(rv[d] == 1'b0, "R8 single response", 32'(rv[d]), 0);
  endtask

  int addrs [8] = '{'h010, 'hFF0, 'h020, 'h1000, 'h20010, 'h20FF0, 'h21000, 'h3FFF0};

  initial begin
    for (int d = 0; d < 2; d++) begin m_s[d] = 32'h5EC0_0000; m_ns[d] = 32'h0A5E_0000; end
    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++)
      chk(rv[d] == 1'b0 && dv[d] == 1'b0, "R10 reset state", 32'(rv[d]), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++)
      for (int sv = 0; sv < 2; sv++)
        for (int uv = 0; uv < 2; uv++) begin
          txn(addrs[i], 1'b1, sv[0], uv[0], 32'hC0DE_0000 ^ 32'(addrs[i]) ^ 32'(sv * 2 + uv));
          txn(addrs[i], 1'b0, sv[0], uv[0], '0);
        end
    // Backpressure on a main-window forward, then on a local answer.
    @(negedge clk);
    stub_ready = 1'b0;
    req_addr = 18'h010; req_write = 1'b0; req_secure = 1'b1; req_user = 1'b0; req_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      for (int d = 0; d < 2; d++) begin
        chk(rdy[d] == 1'b0 && dv[d] == 1'b1, "R9 ready follows downstream", 32'(rdy[d]), 0);
        chk(rv[d] == 1'b0, "R8 no response while stalled", 32'(rv[d]), 0);
      end
    end
    stub_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int d = 0; d < 2; d++)
      chk(rv[d] == 1'b1 && rd[d] == (d == 0 ? m_s[d] : m_ns[d]), "R9/R1 stalled read completes",
          rd[d], d == 0 ? m_s[d] : m_ns[d]);
    stub_ready = 1'b0;
    req_addr = 18'h20010; req_secure = 1'b0; req_valid = 1'b1;
    #1;
    for (int d = 0; d < 2; d++)
      chk(rdy[d] == 1'b1 && dv[d] == 1'b0, "R9 local answer ready", 32'(rdy[d]), 1);
    @(negedge clk);
    req_valid = 1'b0;
    stub_ready = 1'b1;
    chk(rd[0] == 32'h0 && re[0] == 1'b0, "R3 zero under backpressure", rd[0], 0);
    chk(re[1] == 1'b1, "R6 no alias without feature", 32'(re[1]), 1);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule